// File: doc/BRIEF.md
# Privileged Address Segment Decoder

This block sits between address generation and translation in a 32-bit processor. For every access it takes the virtual address, the privilege mode, an error-level flag and a read/write flag. The address space is split into five fixed windows by its three top bits. The block decides whether the window is permitted in the current mode. It then either forms the physical address directly or hands the request to a translation lookaside buffer (TLB) port. If the window is not permitted, it reports an address error.

The block is purely combinational, so a result is ready in the same cycle as its inputs. The house style calls for a state machine, but this block has no states. Its sequencing is a three-stage chain of decoders:

- classify: which window the address falls in.
- route: one of BAD, DIRECT, IDENT or TLB.
- select: which source drives each output.

For TLB-routed accesses, the TLB answers on the same port in the same cycle. The block merges that status with its own address-error case into one result code.

The two unmapped kernel windows both alias the lowest 512 MB of physical space. Each one subtracts its own base address. When the error-level flag is set, the low user half becomes an identity map with read and write access, and the TLB is bypassed.

Top module: `seg_decoder`

## Requirements
- R1: With the error-level flag clear, any address whose top bit is 0 is sent to the TLB in every mode. This means `tlb_req`=1, `tlb_vaddr` equals `vaddr` and `tlb_is_write` equals `is_write`.
- R2: With the error-level flag set, an address whose top bit is 0 is identity-mapped. The outputs are `paddr`=`vaddr`, `acc_valid`=1, `acc_writable`=1, `result`=000 and `tlb_req`=0.
- R3: In kernel mode, addresses 0x80000000..0x9FFFFFFF give `paddr` = `vaddr` − 0x80000000, `acc_valid`=1, `acc_writable`=1, `result`=000 and `tlb_req`=0.
- R4: In kernel mode, addresses 0xA0000000..0xBFFFFFFF give `paddr` = `vaddr` − 0xA0000000, with the same flags as R3. Both windows therefore alias the same low physical region.
- R5: Addresses 0xC0000000..0xDFFFFFFF go to the TLB in supervisor or kernel mode, and give an address error in user mode.
- R6: Addresses 0xE0000000..0xFFFFFFFF go to the TLB in kernel mode only, and give an address error otherwise.
- R7: An address error gives `result`=001 with `paddr`=0, `acc_valid`=0, `acc_writable`=0 and `tlb_req`=0. In that case `tlb_vaddr` and `tlb_is_write` are driven to 0.
- R8: The mode code is 00 kernel, 01 supervisor, 10 user. Code 11 behaves exactly as user.
- R9: While `tlb_req`=1, the TLB status maps to `result` as follows: 00 hit → 000, 01 no match → 010, 10 entry invalid → 011, 11 write to a clean page → 100. A hit gives `paddr`=`tlb_paddr`, `acc_valid`=1 and `acc_writable`=`tlb_writable`. Any other status gives `paddr`=0, `acc_valid`=0 and `acc_writable`=0.
- R10: While `tlb_req`=0, the inputs `tlb_paddr`, `tlb_status` and `tlb_writable` have no effect on any output.
- R11: The error-level flag changes only the low half. Addresses with the top bit set decode the same way whether the flag is set or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vaddr | input | 32 | Virtual address of the access |
| priv_mode | input | 2 | Privilege mode: 00 kernel, 01 supervisor, 10/11 user |
| err_level | input | 1 | Error-level flag; identity-maps the low half |
| is_write | input | 1 | 1 for a store, 0 for a load |
| tlb_req | output | 1 | Translation request strobe to the TLB |
| tlb_vaddr | output | 32 | Address sent to the TLB (0 when no request) |
| tlb_is_write | output | 1 | Write flag sent to the TLB (0 when no request) |
| tlb_paddr | input | 32 | Physical address returned by the TLB |
| tlb_status | input | 2 | TLB status: 00 hit, 01 no match, 10 invalid, 11 clean page written |
| tlb_writable | input | 1 | TLB entry allows writes |
| paddr | output | 32 | Resulting physical address |
| acc_valid | output | 1 | Access may proceed |
| acc_writable | output | 1 | Page may be written |
| result | output | 3 | 000 ok, 001 address error, 010 no match, 011 invalid, 100 clean page written |

## Verification
The assertions assume the TLB answers in the same evaluation as the request. They also assume the TLB inputs only matter while a request is raised. The bench applies every input vector at a rising edge, holds it for the whole cycle and samples at the falling edge. Each check therefore sees settled combinational values. The TLB return inputs are driven with deliberately conflicting values whenever the block is expected to ignore them.

// File: rtl/seg_decoder_pkg.sv
package seg_decoder_pkg;

    typedef enum logic [1:0] {
        PRIV_KERNEL   = 2'b00,
        PRIV_SUPER    = 2'b01,
        PRIV_USER     = 2'b10,
        PRIV_USER_ALT = 2'b11
    } priv_e;

    typedef enum logic [2:0] {
        SEG_USER     = 3'd0,
        SEG_KDIRECT0 = 3'd1,
        SEG_KDIRECT1 = 3'd2,
        SEG_SUPER    = 3'd3,
        SEG_KMAPPED  = 3'd4
    } seg_e;

    typedef enum logic [1:0] {
        ROUTE_BAD    = 2'd0,
        ROUTE_DIRECT = 2'd1,
        ROUTE_IDENT  = 2'd2,
        ROUTE_TLB    = 2'd3
    } route_e;

    typedef enum logic [1:0] {
        TLB_HIT     = 2'd0,
        TLB_MISS    = 2'd1,
        TLB_INVALID = 2'd2,
        TLB_MODIFY  = 2'd3
    } tlb_stat_e;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_BADADDR = 3'd1,
        RES_MISS    = 3'd2,
        RES_INVALID = 3'd3,
        RES_MODIFY  = 3'd4
    } result_e;

endpackage

// File: rtl/seg_classify.sv
module seg_classify
    import seg_decoder_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] va,
    output seg_e              seg,
    output logic [ADDR_W-1:0] window_base
);
    localparam int SEL_W   = 3;
    localparam int SEL_LSB = ADDR_W - SEL_W;

    logic [SEL_W-1:0] sel;

    always_comb begin
        sel         = va[ADDR_W-1:SEL_LSB];
        seg         = SEG_USER;
        window_base = '0;
        unique casez (sel)
            3'b0??: begin
                seg = SEG_USER;
            end
            3'b100: begin
                seg         = SEG_KDIRECT0;
                window_base = {3'b100, {SEL_LSB{1'b0}}};
            end
            3'b101: begin
                seg         = SEG_KDIRECT1;
                window_base = {3'b101, {SEL_LSB{1'b0}}};
            end
            3'b110: begin
                seg = SEG_SUPER;
            end
            3'b111: begin
                seg = SEG_KMAPPED;
            end
            default: begin
                seg = SEG_USER;
            end
        endcase
    end
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
    import seg_decoder_pkg::*;
(
    input  seg_e       seg,
    input  logic [1:0] priv,
    input  logic       err_level,
    output route_e     route
);
    logic is_kernel;
    logic is_super;

    always_comb begin
        is_kernel = (priv == PRIV_KERNEL);
        is_super  = (priv == PRIV_SUPER);
    end

    always_comb begin
        route = ROUTE_BAD;
        unique case (seg)
            SEG_USER:     route = err_level ? ROUTE_IDENT : ROUTE_TLB;
            SEG_KDIRECT0,
            SEG_KDIRECT1: route = is_kernel ? ROUTE_DIRECT : ROUTE_BAD;
            SEG_SUPER:    route = (is_kernel || is_super) ? ROUTE_TLB : ROUTE_BAD;
            SEG_KMAPPED:  route = is_kernel ? ROUTE_TLB : ROUTE_BAD;
            default:      route = ROUTE_BAD;
        endcase
    end
endmodule

// File: rtl/seg_xlate_mux.sv
module seg_xlate_mux
    import seg_decoder_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  route_e            route,
    input  logic [ADDR_W-1:0] va,
    input  logic [ADDR_W-1:0] window_base,
    input  logic              is_write,
    input  logic [ADDR_W-1:0] tlb_paddr,
    input  logic [1:0]        tlb_status,
    input  logic              tlb_writable,
    output logic              tlb_req,
    output logic [ADDR_W-1:0] tlb_vaddr,
    output logic              tlb_is_write,
    output logic [ADDR_W-1:0] paddr,
    output logic              acc_valid,
    output logic              acc_writable,
    output logic [2:0]        result
);
    logic [ADDR_W-1:0] direct_pa;

    always_comb begin
        direct_pa = va - window_base;
    end

    always_comb begin
        tlb_req      = 1'b0;
        tlb_vaddr    = '0;
        tlb_is_write = 1'b0;
        paddr        = '0;
        acc_valid    = 1'b0;
        acc_writable = 1'b0;
        result       = RES_BADADDR;
        unique case (route)
            ROUTE_BAD: begin
                result = RES_BADADDR;
            end
            ROUTE_DIRECT: begin
                paddr        = direct_pa;
                acc_valid    = 1'b1;
                acc_writable = 1'b1;
                result       = RES_OK;
            end
            ROUTE_IDENT: begin
                paddr        = va;
                acc_valid    = 1'b1;
                acc_writable = 1'b1;
                result       = RES_OK;
            end
            ROUTE_TLB: begin
                tlb_req      = 1'b1;
                tlb_vaddr    = va;
                tlb_is_write = is_write;
                unique case (tlb_status)
                    TLB_HIT: begin
                        paddr        = tlb_paddr;
                        acc_valid    = 1'b1;
                        acc_writable = tlb_writable;
                        result       = RES_OK;
                    end
                    TLB_MISS:    result = RES_MISS;
                    TLB_INVALID: result = RES_INVALID;
                    TLB_MODIFY:  result = RES_MODIFY;
                    default:     result = RES_MISS;
                endcase
            end
            default: begin
                result = RES_BADADDR;
            end
        endcase
    end
endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
    import seg_decoder_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [1:0]        priv_mode,
    input  logic              err_level,
    input  logic              is_write,
    output logic              tlb_req,
    output logic [ADDR_W-1:0] tlb_vaddr,
    output logic              tlb_is_write,
    input  logic [ADDR_W-1:0] tlb_paddr,
    input  logic [1:0]        tlb_status,
    input  logic              tlb_writable,
    output logic [ADDR_W-1:0] paddr,
    output logic              acc_valid,
    output logic              acc_writable,
    output logic [2:0]        result
);
    localparam int HALF_W = ADDR_W - 3;

    seg_e              seg;
    route_e            route;
    logic [ADDR_W-1:0] window_base;

    seg_classify #(.ADDR_W(ADDR_W)) u_classify (
        .va          (vaddr),
        .seg         (seg),
        .window_base (window_base)
    );

    seg_access_check u_access (
        .seg       (seg),
        .priv      (priv_mode),
        .err_level (err_level),
        .route     (route)
    );

    seg_xlate_mux #(.ADDR_W(ADDR_W)) u_xlate (
        .route        (route),
        .va           (vaddr),
        .window_base  (window_base),
        .is_write     (is_write),
        .tlb_paddr    (tlb_paddr),
        .tlb_status   (tlb_status),
        .tlb_writable (tlb_writable),
        .tlb_req      (tlb_req),
        .tlb_vaddr    (tlb_vaddr),
        .tlb_is_write (tlb_is_write),
        .paddr        (paddr),
        .acc_valid    (acc_valid),
        .acc_writable (acc_writable),
        .result       (result)
    );

    always_comb begin
        // R7: an address error never reaches the TLB and never grants access
        p_bad_quiet_r7: assert (result != RES_BADADDR || (!tlb_req && !acc_valid && paddr == '0))
            else $error("bad address leaked");
        // R2: error level flag bypasses the TLB for the low half
        p_erl_ident_r2: assert (!(err_level && !vaddr[ADDR_W-1]) || (!tlb_req && paddr == vaddr && acc_writable))
            else $error("identity map broken");
        // R8: user codes never reach the upper half
        p_user_upper_r8: assert (!(priv_mode[1] && vaddr[ADDR_W-1]) || result == RES_BADADDR)
            else $error("user reached upper half");
        // R3: kernel direct windows land in the low physical region
        p_kdirect_low_r3: assert (!(priv_mode == PRIV_KERNEL && vaddr[ADDR_W-1:ADDR_W-2] == 2'b10)
                                   || (!tlb_req && paddr[ADDR_W-1:HALF_W] == 3'b000 && acc_valid))
            else $error("direct window off");
        // R9: access granted exactly when result is ok
        p_valid_ok_r9: assert (acc_valid == (result == RES_OK))
            else $error("valid and result disagree");
        // R1: a raised request carries the access address
        p_req_addr_r1: assert (!tlb_req || (tlb_vaddr == vaddr && tlb_is_write == is_write))
            else $error("request address wrong");
    end
endmodule

// File: tb/seg_decoder_test.sv
module seg_decoder_test;
    logic        clk = 1'b0;
    logic [31:0] vaddr = '0;
    logic [1:0]  priv_mode = '0;
    logic        err_level = 1'b0;
    logic        is_write = 1'b0;
    logic [31:0] tlb_paddr = '0;
    logic [1:0]  tlb_status = '0;
    logic        tlb_writable = 1'b0;
    logic        tlb_req;
    logic [31:0] tlb_vaddr;
    logic        tlb_is_write;
    logic [31:0] paddr;
    logic        acc_valid;
    logic        acc_writable;
    logic [2:0]  result;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    seg_decoder uut (
        .vaddr(vaddr), .priv_mode(priv_mode), .err_level(err_level), .is_write(is_write),
        .tlb_req(tlb_req), .tlb_vaddr(tlb_vaddr), .tlb_is_write(tlb_is_write),
        .tlb_paddr(tlb_paddr), .tlb_status(tlb_status), .tlb_writable(tlb_writable),
        .paddr(paddr), .acc_valid(acc_valid), .acc_writable(acc_writable), .result(result)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [31:0] va, input logic [1:0] md, input logic erl,
                         input logic wr, input logic [31:0] tpa, input logic [1:0] tst,
                         input logic twr);
        @(posedge clk);
        vaddr = va; priv_mode = md; err_level = erl; is_write = wr;
        tlb_paddr = tpa; tlb_status = tst; tlb_writable = twr;
        @(negedge clk);
    endtask

    task automatic expect_direct(input string tag, input logic [31:0] pa);
        chk({tag, " paddr"}, paddr, pa);
        chk({tag, " valid"}, {31'd0, acc_valid}, 32'd1);
        chk({tag, " wr"}, {31'd0, acc_writable}, 32'd1);
        chk({tag, " res"}, {29'd0, result}, 32'd0);
        chk({tag, " req"}, {31'd0, tlb_req}, 32'd0);
    endtask

    task automatic expect_bad(input string tag);
        chk({tag, " res"}, {29'd0, result}, 32'd1);
        chk({tag, " paddr"}, paddr, 32'd0);
        chk({tag, " valid"}, {30'd0, acc_valid, acc_writable}, 32'd0);
        chk({tag, " req"}, {31'd0, tlb_req}, 32'd0);
        chk({tag, " tva"}, tlb_vaddr, 32'd0);
        chk({tag, " twr"}, {31'd0, tlb_is_write}, 32'd0);
    endtask

    task automatic expect_req(input string tag, input logic [31:0] va, input logic wr);
        chk({tag, " req"}, {31'd0, tlb_req}, 32'd1);
        chk({tag, " tva"}, tlb_vaddr, va);
        chk({tag, " twr"}, {31'd0, tlb_is_write}, {31'd0, wr});
    endtask

    task automatic t_idle();
        @(negedge clk);
        expect_req("R1 idle", 32'h0, 1'b0);
        chk("R1 idle res", {29'd0, result}, 32'd0);
    endtask

    task automatic t_useg_tlb();
        for (int m = 0; m < 4; m++) begin
            apply(32'h1234_5678, m[1:0], 1'b0, 1'b1, 32'h0, 2'd1, 1'b0);
            expect_req("R1 useg mode", 32'h1234_5678, 1'b1);
            chk("R1 useg miss res", {29'd0, result}, 32'd2);
        end
    endtask

    task automatic t_erl_ident();
        apply(32'h7FFF_FFFC, 2'b10, 1'b1, 1'b1, 32'hDEAD_BEEF, 2'd3, 1'b0);
        expect_direct("R2 erl", 32'h7FFF_FFFC);
        chk("R2 erl tva", tlb_vaddr, 32'd0);
    endtask

    task automatic t_kdirect0();
        apply(32'h8000_0000, 2'b00, 1'b0, 1'b0, 32'h0, 2'd0, 1'b0);
        expect_direct("R3 k0 low", 32'h0);
        apply(32'h9FFF_FFFF, 2'b00, 1'b0, 1'b1, 32'h0, 2'd0, 1'b0);
        expect_direct("R3 k0 high", 32'h1FFF_FFFF);
    endtask

    task automatic t_kdirect1();
        apply(32'hA000_1000, 2'b00, 1'b0, 1'b0, 32'h0, 2'd0, 1'b0);
        expect_direct("R4 k1 alias", 32'h0000_1000);
        apply(32'hBFFF_FFFF, 2'b00, 1'b0, 1'b0, 32'h0, 2'd0, 1'b0);
        expect_direct("R4 k1 high", 32'h1FFF_FFFF);
    endtask

    task automatic t_super_seg();
        apply(32'hC000_0000, 2'b01, 1'b0, 1'b0, 32'h0, 2'd1, 1'b0);
        expect_req("R5 super", 32'hC000_0000, 1'b0);
        apply(32'hDFFF_FFF0, 2'b00, 1'b0, 1'b1, 32'h0, 2'd1, 1'b0);
        expect_req("R5 kernel", 32'hDFFF_FFF0, 1'b1);
        apply(32'hC000_0000, 2'b10, 1'b0, 1'b0, 32'h0, 2'd0, 1'b1);
        expect_bad("R5 user");
        apply(32'hC000_0000, 2'b11, 1'b0, 1'b0, 32'h0, 2'd0, 1'b1);
        expect_bad("R8 alt user");
    endtask

    task automatic t_kmapped();
        apply(32'hE000_0000, 2'b00, 1'b0, 1'b0, 32'h0, 2'd1, 1'b0);
        expect_req("R6 kernel", 32'hE000_0000, 1'b0);
        apply(32'hFFFF_FFFF, 2'b01, 1'b0, 1'b0, 32'h0, 2'd0, 1'b1);
        expect_bad("R6 super");
    endtask

    task automatic t_bad_direct();
        apply(32'h8000_0000, 2'b10, 1'b0, 1'b1, 32'hFFFF_FFFF, 2'd0, 1'b1);
        expect_bad("R7 user k0");
        apply(32'hA000_0000, 2'b01, 1'b0, 1'b1, 32'hFFFF_FFFF, 2'd0, 1'b1);
        expect_bad("R7 super k1");
    endtask

    task automatic t_tlb_status();
        apply(32'hC000_2000, 2'b00, 1'b0, 1'b0, 32'h0ABC_D000, 2'd0, 1'b1);
        chk("R9 hit paddr", paddr, 32'h0ABC_D000);
        chk("R9 hit flags", {29'd0, acc_valid, acc_writable, 1'b0}, 32'd6);
        chk("R9 hit res", {29'd0, result}, 32'd0);
        apply(32'hC000_2000, 2'b00, 1'b0, 1'b0, 32'h0ABC_D000, 2'd0, 1'b0);
        chk("R9 hit ro", {30'd0, acc_valid, acc_writable}, 32'd2);
        apply(32'hC000_2000, 2'b00, 1'b0, 1'b1, 32'h0ABC_D000, 2'd1, 1'b1);
        chk("R9 miss res", {29'd0, result}, 32'd2);
        chk("R9 miss paddr", paddr, 32'd0);
        apply(32'hC000_2000, 2'b00, 1'b0, 1'b1, 32'h0ABC_D000, 2'd2, 1'b1);
        chk("R9 inval res", {29'd0, result}, 32'd3);
        chk("R9 inval flags", {30'd0, acc_valid, acc_writable}, 32'd0);
        apply(32'hC000_2000, 2'b00, 1'b0, 1'b1, 32'h0ABC_D000, 2'd3, 1'b1);
        chk("R9 modify res", {29'd0, result}, 32'd4);
    endtask

    task automatic t_ignore_tlb();
        apply(32'h8000_4000, 2'b00, 1'b0, 1'b0, 32'hFFFF_FFFF, 2'd3, 1'b0);
        expect_direct("R10 direct", 32'h0000_4000);
        apply(32'h8000_4000, 2'b00, 1'b0, 1'b0, 32'h1111_0000, 2'd1, 1'b1);
        expect_direct("R10 direct b", 32'h0000_4000);
    endtask

    task automatic t_erl_upper();
        apply(32'hA000_0010, 2'b00, 1'b1, 1'b0, 32'h0, 2'd0, 1'b0);
        expect_direct("R11 erl k1", 32'h0000_0010);
        apply(32'hC000_0000, 2'b10, 1'b1, 1'b0, 32'h0, 2'd0, 1'b0);
        expect_bad("R11 erl user upper");
        apply(32'hE000_0040, 2'b00, 1'b1, 1'b1, 32'h0, 2'd1, 1'b0);
        expect_req("R11 erl kmapped", 32'hE000_0040, 1'b1);
    endtask

    initial begin
        t_idle();
        t_useg_tlb();
        t_erl_ident();
        t_kdirect0();
        t_kdirect1();
        t_super_seg();
        t_kmapped();
        t_bad_direct();
        t_tlb_status();
        t_ignore_tlb();
        t_erl_upper();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog got=hung exp=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule